// File: doc/BRIEF.md
# Shared-Pin Configuration Mode Entry Controller

This block decides when a motor pre-driver stops acting on its gate command inputs and hands its shared pins to a serial configuration port, and when it gives them back. While the bridge is idle (enable low, no fault report waiting for acknowledgement, every high-side command high and every low-side command low), a low pulse on the fault line whose width falls inside a window of clock counts switches the block into configuration mode. Pulses that are too short or too long are ignored. If any idle condition drops during the pulse, measurement starts again from zero.

Raising enable in configuration mode starts the way back: any nonvolatile write still in progress is allowed to finish, then a reload of stored settings into working registers is requested. During both the wait and the reload the fault line is pulled low and the gates stay blocked. The same reload runs after reset. A stored serial-enable bit gates entry; it can be cleared only while in configuration mode and nothing in the block can set it again.

Top module: `cfg_mode_ctrl`

## Requirements
- R1: After reset the block is in the reload phase: reload_req_o=1, fault_hold_o=1, gate_block_o=1, config_mode_o=0; this holds until reload_done_i=1 is sampled, after which all four outputs are 0 (normal mode).
- R2: Entry is refused when enable_i=1 or fault_pending_i=1 during the pulse.
- R3: Entry is refused unless hs_cmd_i is all ones and ls_cmd_i is all zeros during the pulse.
- R4: A pulse is counted as the number of consecutive clock edges at which fault_line_i=0 with all entry conditions met; when fault_line_i is next sampled 1, config_mode_o rises one cycle later if the count lies in [PULSE_MIN, PULSE_MAX] (2048 and 4096 by default) and otherwise nothing changes.
- R5: If any entry condition is lost while the line is low, the count restarts from zero when the conditions return.
- R6: In configuration mode config_mode_o=1, gate_block_o=1, fault_hold_o=0 and reload_req_o=0.
- R7: enable_i=1 in configuration mode leaves it; while write_busy_i=1 the block waits with fault_hold_o=1, gate_block_o=1 and reload_req_o=0; once write_busy_i=0 it enters the reload phase of R1.
- R8: ser_en_o is 1 after reset; clr_ser_en_i=1 clears it only in configuration mode and is ignored elsewhere; once 0 it stays 0 and entry is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Bridge enable input |
| hs_cmd_i | input | N_PH | High-side gate command inputs |
| ls_cmd_i | input | N_PH | Low-side gate command inputs |
| fault_pending_i | input | 1 | Unacknowledged fault report waiting |
| fault_line_i | input | 1 | Sampled level of the shared fault line |
| write_busy_i | input | 1 | Nonvolatile write in progress |
| reload_done_i | input | 1 | Register reload finished |
| clr_ser_en_i | input | 1 | Request to clear the serial-enable bit |
| config_mode_o | output | 1 | Configuration mode active |
| reload_req_o | output | 1 | Register reload requested |
| fault_hold_o | output | 1 | Pull the fault line low |
| gate_block_o | output | 1 | Block all gate outputs |
| ser_en_o | output | 1 | Stored serial-enable bit |

## Verification
The assertions assume fault_line_i, enable_i and the command inputs are already synchronous to clk_i and that reload_done_i is only raised while a reload is requested. The stimulus changes every input on the falling clock edge and raises reload_done_i only after observing reload_req_o high, so each rising edge sees settled, single-valued inputs. Pulse widths are driven as exact counts of low-sampled edges, which lets the window edges be hit to the cycle.

// File: rtl/cfg_mode_pkg.sv
package cfg_mode_pkg;
  typedef enum logic [1:0] {
    ST_RELOAD = 2'd0,
    ST_NORMAL = 2'd1,
    ST_CONFIG = 2'd2,
    ST_DRAIN  = 2'd3
  } cfg_state_e;
endpackage

// File: rtl/cfg_pulse_meas.sv
module cfg_pulse_meas #(
  parameter int PULSE_MIN = 2048,
  parameter int PULSE_MAX = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic line_i,
  output logic hit_o
);
  localparam int SAT = PULSE_MAX + 1;
  localparam int CW  = $clog2(SAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!arm_i || line_i)  cnt_q <= '0;
    else if (cnt_q != CW'(SAT)) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = arm_i && line_i &&
                 (cnt_q >= CW'(PULSE_MIN)) && (cnt_q <= CW'(PULSE_MAX));

  // restart on lost condition
  p_cnt_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !hit_o);
endmodule

// File: rtl/cfg_mode_fsm.sv
module cfg_mode_fsm
  import cfg_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic enable_i,
  input  logic write_busy_i,
  input  logic reload_done_i,
  input  logic clr_ser_en_i,
  output logic normal_o,
  output logic config_mode_o,
  output logic reload_req_o,
  output logic fault_hold_o,
  output logic gate_block_o,
  output logic ser_en_o
);
  cfg_state_e state_q, state_d;
  logic       ser_en_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RELOAD: if (reload_done_i) state_d = ST_NORMAL;
      ST_NORMAL: if (hit_i)         state_d = ST_CONFIG;
      ST_CONFIG: if (enable_i)      state_d = ST_DRAIN;
      ST_DRAIN:  if (!write_busy_i) state_d = ST_RELOAD;
      default:                      state_d = ST_RELOAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RELOAD;
    else         state_q <= state_d;
  end

  // one-way clear, only in config mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  ser_en_q <= 1'b1;
    else if (state_q == ST_CONFIG && clr_ser_en_i) ser_en_q <= 1'b0;
  end

  assign normal_o      = (state_q == ST_NORMAL);
  assign config_mode_o = (state_q == ST_CONFIG);
  assign reload_req_o  = (state_q == ST_RELOAD);
  assign fault_hold_o  = (state_q == ST_RELOAD) || (state_q == ST_DRAIN);
  assign gate_block_o  = (state_q != ST_NORMAL);
  assign ser_en_o      = ser_en_q;

  p_ser_en_no_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_q |=> !ser_en_q);

  p_reload_until_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_req_o && !reload_done_i |=> reload_req_o);

  p_write_completes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reload_req_o) |-> !$past(write_busy_i));
endmodule

// File: rtl/cfg_mode_ctrl.sv
module cfg_mode_ctrl #(
  parameter int N_PH      = 3,
  parameter int PULSE_MIN = 2048,
  parameter int PULSE_MAX = 4096
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic [N_PH-1:0] hs_cmd_i,
  input  logic [N_PH-1:0] ls_cmd_i,
  input  logic            fault_pending_i,
  input  logic            fault_line_i,
  input  logic            write_busy_i,
  input  logic            reload_done_i,
  input  logic            clr_ser_en_i,
  output logic            config_mode_o,
  output logic            reload_req_o,
  output logic            fault_hold_o,
  output logic            gate_block_o,
  output logic            ser_en_o
);
  logic idle_ok, normal, arm, hit;

  assign idle_ok = !enable_i && !fault_pending_i && (&hs_cmd_i) && !(|ls_cmd_i) && ser_en_o;
  assign arm     = normal && idle_ok;

  cfg_pulse_meas #(
    .PULSE_MIN(PULSE_MIN),
    .PULSE_MAX(PULSE_MAX)
  ) u_meas (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (arm),
    .line_i(fault_line_i),
    .hit_o (hit)
  );

  cfg_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .enable_i     (enable_i),
    .write_busy_i (write_busy_i),
    .reload_done_i(reload_done_i),
    .clr_ser_en_i (clr_ser_en_i),
    .normal_o     (normal),
    .config_mode_o(config_mode_o),
    .reload_req_o (reload_req_o),
    .fault_hold_o (fault_hold_o),
    .gate_block_o (gate_block_o),
    .ser_en_o     (ser_en_o)
  );

  p_entry_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(config_mode_o) |-> $past(!enable_i && !fault_pending_i && ser_en_o));

  p_entry_pattern_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(config_mode_o) |-> $past((&hs_cmd_i) && !(|ls_cmd_i) && fault_line_i));

  p_cfg_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    config_mode_o |-> gate_block_o && !fault_hold_o);
endmodule

// File: tb/cfg_mode_ctrl_tb.sv
module cfg_mode_ctrl_tb;
  localparam int N_PH = 3;
  localparam int PMIN = 2048;
  localparam int PMAX = 4096;
  localparam int NV   = 9;

  // {width[12:0], en, pend, hs[2:0], ls[2:0], expect_entry}
  localparam logic [21:0] VEC [NV] = '{
    {13'd2047, 1'b0, 1'b0, 3'b111, 3'b000, 1'b0},
    {13'd2048, 1'b0, 1'b0, 3'b111, 3'b000, 1'b1},
    {13'd4096, 1'b0, 1'b0, 3'b111, 3'b000, 1'b1},
    {13'd4097, 1'b0, 1'b0, 3'b111, 3'b000, 1'b0},
    {13'd3000, 1'b0, 1'b0, 3'b110, 3'b000, 1'b0},
    {13'd3000, 1'b0, 1'b0, 3'b111, 3'b001, 1'b0},
    {13'd3000, 1'b1, 1'b0, 3'b111, 3'b000, 1'b0},
    {13'd3000, 1'b0, 1'b1, 3'b111, 3'b000, 1'b0},
    {13'd3000, 1'b0, 1'b0, 3'b111, 3'b000, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pend = 1'b0, line = 1'b1, busy = 1'b0, rdone = 1'b0, clr = 1'b0;
  logic [N_PH-1:0] hs = '1, ls = '0;
  logic cfg, req, hold, blk, ser;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  cfg_mode_ctrl #(.N_PH(N_PH), .PULSE_MIN(PMIN), .PULSE_MAX(PMAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .hs_cmd_i(hs), .ls_cmd_i(ls),
    .fault_pending_i(pend), .fault_line_i(line), .write_busy_i(busy),
    .reload_done_i(rdone), .clr_ser_en_i(clr), .config_mode_o(cfg),
    .reload_req_o(req), .fault_hold_o(hold), .gate_block_o(blk), .ser_en_o(ser));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // outputs packed as {cfg, req, hold, blk}
  function automatic logic [3:0] outs();
    return {cfg, req, hold, blk};
  endfunction

  task automatic pulse(input int w);
    line = 1'b0;
    repeat (w) @(negedge clk);
    line = 1'b1;
    @(negedge clk);
  endtask

  task automatic leave_cfg();
    busy = 1'b1; en = 1'b1;
    @(negedge clk);
    check("R7 drain outputs", outs(), 4'b0011);
    repeat (3) @(negedge clk);
    check("R7 write still busy", outs(), 4'b0011);
    busy = 1'b0;
    @(negedge clk);
    check("R7 reload after write", outs(), 4'b0111);
    rdone = 1'b1;
    @(negedge clk);
    rdone = 1'b0;
    check("R1 back to normal", outs(), 4'b0000);
    en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", outs(), 4'b0111);
    check("R8 ser_en reset", ser, 1'b1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 held until done", outs(), 4'b0111);
    rdone = 1'b1;
    @(negedge clk);
    rdone = 1'b0;
    check("R1 normal after done", outs(), 4'b0000);

    // R2 R3 R4 table
    for (int i = 0; i < NV; i++) begin
      en = VEC[i][8]; pend = VEC[i][7]; hs = VEC[i][6:4]; ls = VEC[i][3:1];
      @(negedge clk);
      pulse(int'(VEC[i][21:9]));
      check($sformatf("R2 R3 R4 vec %0d entry", i), cfg, VEC[i][0]);
      en = 1'b0; pend = 1'b0; hs = '1; ls = '0;
      if (VEC[i][0]) begin
        check("R6 config outputs", outs(), 4'b1001);
        leave_cfg();
      end
    end

    // R5: condition lost mid-pulse, remaining low part too short
    line = 1'b0;
    repeat (1500) @(negedge clk);
    pend = 1'b1;
    @(negedge clk);
    pend = 1'b0;
    repeat (1000) @(negedge clk);
    line = 1'b1;
    @(negedge clk);
    check("R5 restart blocks entry", cfg, 1'b0);
    // R5: after restart a full-width remainder still enters
    line = 1'b0;
    repeat (100) @(negedge clk);
    hs = 3'b011;
    @(negedge clk);
    hs = '1;
    pulse(2048);
    check("R5 restart then valid", cfg, 1'b1);

    // R8: clear in config
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R8 cleared in config", ser, 1'b0);
    leave_cfg();
    check("R8 stays cleared", ser, 1'b0);
    pulse(3000);
    check("R8 entry refused", cfg, 1'b0);

    // R8: clear outside config ignored (fresh reset)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rdone = 1'b1;
    @(negedge clk);
    rdone = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R8 clear ignored in normal", ser, 1'b1);
    pulse(2500);
    check("R8 entry still allowed", cfg, 1'b1);

    finish_run();
  end
endmodule